// File: doc/BRIEF.md
# Block Load/Store Address Sequencer

This block turns one block-transfer instruction of a 32-bit RISC core into a series of single-word memory transfers. It takes the instruction's low bits, the current base register value and the program counter. For every register named in the 16-bit selection mask, it issues one word-aligned address, the register index, the transfer direction and, for stores, the data to write. A valid/ready handshake paces the transfers toward the memory port. When the series ends, the block pulses a completion strobe and, if the instruction asks for it, supplies the updated base value for the register file to write.

All four addressing variants (ascending or descending, adjusting the address before or after each access) use the same walk. The block works out the lowest address of the block once, at the start, and then visits the selected registers from index 0 upward, adding one word each step. Nothing is ever scanned in reverse.

Two side conditions are exported as flags and not acted on. The first is a request to reach the user-mode register bank. The second is a request to restore the saved status word, which applies to a load that includes the program counter.

Top module: `ldm_addr_seq`

## Requirements
- R1: Instruction fields: base register index in bits [19:16], selection mask in [15:0], bit 20 = 1 for load / 0 for store, bit 21 = writeback request, bit 22 = bank/status option, bit 23 = 1 ascending / 0 descending, bit 24 = 1 adjust-before / 0 adjust-after. `mem_load_o` shows the direction during transfers, and `wb_reg_o` shows the base index at completion.
- R2: The number of handshaked transfers equals the number of set bits in the selection mask.
- R3: The writeback value is base + 4·n when ascending and base − 4·n when descending, where n is the transfer count. The base is used without alignment.
- R4: The first address is base+4 (ascending, before), base (ascending, after), base−4·n (descending, before) or base−4·n+4 (descending, after).
- R5: Every transfer address has bits [1:0] cleared.
- R6: Transfers go in ascending register index order. Each address is 4 above the previous one.
- R7: On a store of register 15, `mem_wdata_o` is the program counter captured at start plus 4. For any other register, it is `rf_rdata_i`.
- R8: For a load with bit 22 set and register 15 in the mask, `status_restore_o` pulses together with `done_o`. For bit 22 set in any other case, `user_bank_o` is high for the whole busy period. The two flags are never high together.
- R9: With an empty mask, there are no transfers and `done_o` comes one cycle after the start. `wb_en_o` stays low even when writeback is requested.
- R10: While `mem_valid_o` is high and `mem_ready_i` is low, the address, register index and direction stay unchanged. The block advances only on a handshake.
- R11: `wb_en_o` is high only in the `done_o` cycle, and only when bit 21 was set and the mask is non-empty.
- R12: `busy_o` is high from the cycle after an accepted start through the `done_o` cycle. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a sequence (taken only when idle) |
| instr_i | input | 25 | Instruction bits [24:0] |
| base_i | input | 32 | Base register value |
| pc_i | input | 32 | Program counter value |
| rf_rdata_i | input | 32 | Register file read data for `mem_reg_o` |
| mem_ready_i | input | 1 | Memory accepts the current transfer |
| mem_valid_o | output | 1 | Transfer presented |
| mem_addr_o | output | 32 | Word-aligned transfer address |
| mem_reg_o | output | 4 | Register index of the transfer |
| mem_load_o | output | 1 | 1 = load, 0 = store |
| mem_wdata_o | output | 32 | Store data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion strobe |
| wb_en_o | output | 1 | Base writeback enable |
| wb_reg_o | output | 4 | Base register index for writeback |
| wb_value_o | output | 32 | Updated base value |
| user_bank_o | output | 1 | User-bank access requested |
| status_restore_o | output | 1 | Status restore requested at completion |

## Verification
The bench targets the four start-address variants with unaligned bases, and a full 16-entry mask going downward. A wrong start formula shifts every address by one word or by the whole block. It also applies random backpressure: a sequencer that advances without a handshake skips a register or repeats an address. Other cases are a store of register 15, which must carry the PC plus 4 and not register-file data, and an empty mask with writeback requested, where a careless design would write back an unchanged or garbage base. Start pulses during a running sequence check that a busy sequencer is not restarted. A load of register 15 with the option bit set must choose the status-restore flag and not the user-bank flag.

// File: rtl/lsm_pkg.sv
// Package: shared constants and state type for the block-transfer sequencer.
// Assumes the classic 32-bit encoding; field positions are fixed by decode.
package lsm_pkg;
    localparam int RN_LSB   = 16;
    localparam int LOAD_BIT = 20;
    localparam int WB_BIT   = 21;
    localparam int OPT_BIT  = 22;
    localparam int UP_BIT   = 23;
    localparam int PRE_BIT  = 24;
    localparam int INSTR_W  = PRE_BIT + 1;
    localparam int WORD_B   = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_XFER = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/lsm_decode.sv
// Module: lsm_decode
// Splits the instruction into fields, counts the selected registers and
// forms the aligned first address and the writeback (end) address.
// Assumes LIST_W is a multiple of 8 and equals the mask width in instr.
module lsm_decode
    import lsm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LIST_W = 16,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 5
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [ADDR_W-1:0]  base,
    output logic               is_load,
    output logic               want_wb,
    output logic               opt,
    output logic [IDX_W-1:0]   rn,
    output logic [LIST_W-1:0]  list,
    output logic [CNT_W-1:0]   count,
    output logic [ADDR_W-1:0]  first_addr,
    output logic [ADDR_W-1:0]  end_addr
);
    localparam int NBYTES = LIST_W / 8;

    logic              up, pre;
    logic [3:0]        byte_cnt [NBYTES];
    logic [ADDR_W-1:0] span, raw_first;

    // Field extraction.
    always_comb begin
        is_load = instr[LOAD_BIT];
        want_wb = instr[WB_BIT];
        opt     = instr[OPT_BIT];
        up      = instr[UP_BIT];
        pre     = instr[PRE_BIT];
        rn      = instr[RN_LSB +: IDX_W];
        list    = instr[LIST_W-1:0];
    end

    // Per-byte population counts.
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        always_comb begin
            byte_cnt[b] = '0;
            for (int k = 0; k < 8; k++)
                byte_cnt[b] = byte_cnt[b] + 4'(list[b*8+k]);
        end
    end

    // Sum of the byte counts gives the transfer count.
    always_comb begin
        count = '0;
        for (int b = 0; b < NBYTES; b++)
            count = count + CNT_W'(byte_cnt[b]);
    end

    // End address and first address for the four variants.
    always_comb begin
        span     = ADDR_W'(count) << 2;
        end_addr = up ? base + span : base - span;
        unique case ({up, pre})
            2'b11:   raw_first = base + ADDR_W'(WORD_B);
            2'b10:   raw_first = base;
            2'b01:   raw_first = base - span;
            default: raw_first = base - span + ADDR_W'(WORD_B);
        endcase
        first_addr = {raw_first[ADDR_W-1:2], 2'b00};
    end
endmodule

// File: rtl/lsm_pick.sv
// Module: lsm_pick
// Finds the lowest set bit of the pending mask and returns the mask with
// that bit cleared. Assumes an all-zero mask is never consumed.
module lsm_pick #(
    parameter int LIST_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic [LIST_W-1:0] pending,
    output logic [IDX_W-1:0]  idx,
    output logic [LIST_W-1:0] rest
);
    // Lowest-index priority encoder.
    always_comb begin
        idx = '0;
        for (int i = LIST_W - 1; i >= 0; i--)
            if (pending[i]) idx = IDX_W'(i);
    end

    // Clear the lowest set bit.
    always_comb rest = pending & (pending - LIST_W'(1));
endmodule

// File: rtl/ldm_addr_seq.sv
// Module: ldm_addr_seq
// Sequences one block load/store instruction into single-word transfers
// with a valid/ready memory handshake, ascending register order for all
// addressing variants. Assumes rf_rdata_i follows mem_reg_o combinationally.
module ldm_addr_seq
    import lsm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LIST_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [INSTR_W-1:0]  instr_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [ADDR_W-1:0]   pc_i,
    input  logic [ADDR_W-1:0]   rf_rdata_i,
    input  logic                mem_ready_i,
    output logic                mem_valid_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    output logic [$clog2(LIST_W)-1:0] mem_reg_o,
    output logic                mem_load_o,
    output logic [ADDR_W-1:0]   mem_wdata_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                wb_en_o,
    output logic [$clog2(LIST_W)-1:0] wb_reg_o,
    output logic [ADDR_W-1:0]   wb_value_o,
    output logic                user_bank_o,
    output logic                status_restore_o
);
    localparam int IDX_W  = $clog2(LIST_W);
    localparam int CNT_W  = $clog2(LIST_W + 1);
    localparam int PC_IDX = LIST_W - 1;

    logic              d_load, d_wb, d_opt;
    logic [IDX_W-1:0]  d_rn;
    logic [LIST_W-1:0] d_list;
    logic [CNT_W-1:0]  d_cnt;
    logic [ADDR_W-1:0] d_first, d_end;

    seq_state_t        state_q;
    logic [LIST_W-1:0] pend_q, pend_rest;
    logic [IDX_W-1:0]  cur_idx;
    logic [ADDR_W-1:0] addr_q, end_q, pcp4_q;
    logic [IDX_W-1:0]  rn_q;
    logic              load_q, wb_q, opt_q, pc_sel_q, nonempty_q;
    logic              take;

    lsm_decode #(.ADDR_W(ADDR_W), .LIST_W(LIST_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dec (
        .instr(instr_i), .base(base_i), .is_load(d_load), .want_wb(d_wb),
        .opt(d_opt), .rn(d_rn), .list(d_list), .count(d_cnt),
        .first_addr(d_first), .end_addr(d_end)
    );

    lsm_pick #(.LIST_W(LIST_W), .IDX_W(IDX_W)) u_pick (
        .pending(pend_q), .idx(cur_idx), .rest(pend_rest)
    );

    // A transfer completes on a valid-and-ready handshake.
    always_comb take = (state_q == SEQ_XFER) && mem_ready_i;

    // Sequencer state, captured operands and walk position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEQ_IDLE;
            pend_q     <= '0;
            addr_q     <= '0;
            end_q      <= '0;
            pcp4_q     <= '0;
            rn_q       <= '0;
            load_q     <= 1'b0;
            wb_q       <= 1'b0;
            opt_q      <= 1'b0;
            pc_sel_q   <= 1'b0;
            nonempty_q <= 1'b0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: if (start_i) begin
                    pend_q     <= d_list;
                    addr_q     <= d_first;
                    end_q      <= d_end;
                    pcp4_q     <= pc_i + ADDR_W'(WORD_B);
                    rn_q       <= d_rn;
                    load_q     <= d_load;
                    wb_q       <= d_wb;
                    opt_q      <= d_opt;
                    pc_sel_q   <= d_list[PC_IDX];
                    nonempty_q <= (d_cnt != '0);
                    state_q    <= (d_cnt == '0) ? SEQ_FIN : SEQ_XFER;
                end
                SEQ_XFER: if (take) begin
                    pend_q <= pend_rest;
                    addr_q <= addr_q + ADDR_W'(WORD_B);
                    if (pend_rest == '0) state_q <= SEQ_FIN;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Output drive from the captured state.
    always_comb begin
        busy_o           = (state_q != SEQ_IDLE);
        done_o           = (state_q == SEQ_FIN);
        mem_valid_o      = (state_q == SEQ_XFER);
        mem_addr_o       = addr_q;
        mem_reg_o        = cur_idx;
        mem_load_o       = load_q;
        mem_wdata_o      = (cur_idx == IDX_W'(PC_IDX)) ? pcp4_q : rf_rdata_i;
        wb_en_o          = done_o && wb_q && nonempty_q;
        wb_reg_o         = rn_q;
        wb_value_o       = end_q;
        user_bank_o      = busy_o && opt_q && !(load_q && pc_sel_q);
        status_restore_o = done_o && opt_q && load_q && pc_sel_q;
    end

    // Stall holds the presented transfer (R10).
    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !mem_ready_i) |=>
        (mem_valid_o && $stable(mem_addr_o) && $stable(mem_reg_o) && $stable(mem_load_o)));

    // Next transfer is a higher register one word up (R6).
    assert_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && mem_ready_i) |=>
        (!mem_valid_o || (mem_reg_o > $past(mem_reg_o) &&
                          mem_addr_o == $past(mem_addr_o) + ADDR_W'(WORD_B))));

    // Word alignment of every address (R5).
    assert_word_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o |-> (mem_addr_o[1:0] == 2'b00));

    // Writeback only with completion (R11).
    assert_wb_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> (done_o && busy_o));

    // Busy persists until done (R12).
    assert_busy_until_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    // Flags mutually exclusive (R8).
    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(user_bank_o && status_restore_o));
endmodule

// File: tb/test_ldm_addr_seq.sv
module test_ldm_addr_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [24:0] instr = '0;
    logic [31:0] base = '0, pc = '0, rf_rdata;
    logic        ready = 1'b0;
    logic        valid, load, busy, done, wb_en, ubank, srest;
    logic [31:0] addr, wdata, wb_value;
    logic [3:0]  mreg, wb_reg;
    int          vectors = 0, miscompares = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    assign rf_rdata = 32'hD000_0000 | {28'h0, mreg};

    ldm_addr_seq i_ldm_addr_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .instr_i(instr),
        .base_i(base), .pc_i(pc), .rf_rdata_i(rf_rdata), .mem_ready_i(ready),
        .mem_valid_o(valid), .mem_addr_o(addr), .mem_reg_o(mreg),
        .mem_load_o(load), .mem_wdata_o(wdata), .busy_o(busy), .done_o(done),
        .wb_en_o(wb_en), .wb_reg_o(wb_reg), .wb_value_o(wb_value),
        .user_bank_o(ubank), .status_restore_o(srest)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [24:0] mk(bit pre, bit up, bit opt, bit wb, bit ld,
                                       logic [3:0] rn, logic [15:0] lst);
        return {pre, up, opt, wb, ld, rn, lst};
    endfunction

    // Behavioural reference: build the expected transfer list, then walk it.
    task automatic run_op(input logic [24:0] ins, input logic [31:0] b,
                          input logic [31:0] p, input int ready_pct, input bit poke);
        logic [31:0] q_addr[$];
        int          q_reg[$];
        int          n = 0, taken = 0;
        logic [31:0] span, endv, a;
        bit          ld = ins[20], wbr = ins[21], opt = ins[22], up = ins[23], pre = ins[24];
        bit          stalled = 1'b0;
        bit          srq;
        for (int i = 0; i < 16; i++) if (ins[i]) n++;
        span = 32'(n) * 4;
        endv = up ? b + span : b - span;
        if (up) a = pre ? b + 4 : b;
        else    a = pre ? b - span : b - span + 4;
        a[1:0] = 2'b00;
        for (int i = 0; i < 16; i++) if (ins[i]) begin
            q_addr.push_back(a); q_reg.push_back(i); a = a + 4;
        end
        srq = opt && ld && ins[15];

        @(negedge clk);
        start = 1'b1; instr = ins; base = b; pc = p;
        @(negedge clk);
        start = poke;
        if (poke) begin instr = ins ^ 25'h1F0_FFFF; base = b + 32'h100; end
        chk("R12 busy after start", {31'h0, busy}, 32'h1);
        while (q_addr.size() > 0) begin
            chk(stalled ? "R10 valid held" : "R2 valid", {31'h0, valid}, 32'h1);
            chk(stalled ? "R10 addr held" : "R4/R6 addr", addr, q_addr[0]);
            chk(stalled ? "R10 reg held" : "R6 reg order", {28'h0, mreg}, 32'(q_reg[0]));
            chk("R1 direction", {31'h0, load}, {31'h0, ld});
            if (!ld)
                chk("R7 store data", wdata,
                    (q_reg[0] == 15) ? p + 4 : (32'hD000_0000 | 32'(q_reg[0])));
            chk("R8 user bank", {31'h0, ubank}, {31'h0, opt && !srq});
            chk("R5 aligned", {30'h0, addr[1:0]}, 32'h0);
            ready = ($urandom_range(99) < ready_pct);
            @(posedge clk);
            stalled = !ready;
            if (ready) begin void'(q_addr.pop_front()); void'(q_reg.pop_front()); taken++; end
            @(negedge clk);
            ready = 1'b0;
        end
        chk("R2 transfer count", 32'(taken), 32'(n));
        chk(n == 0 ? "R9 done" : "R11 done", {31'h0, done}, 32'h1);
        chk("R10 no valid at done", {31'h0, valid}, 32'h0);
        chk(n == 0 ? "R9 wb_en" : "R11 wb_en", {31'h0, wb_en}, {31'h0, wbr && n > 0});
        if (wbr && n > 0) begin
            chk("R3 wb value", wb_value, endv);
            chk("R1 wb reg", {28'h0, wb_reg}, {28'h0, ins[19:16]});
        end
        chk("R8 status restore", {31'h0, srest}, {31'h0, srq});
        start = 1'b0;
        @(negedge clk);
        chk("R12 idle after done", {30'h0, busy, done}, 32'h0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL R12 watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R12 reset busy", {31'h0, busy}, 32'h0);
        chk("R11 reset done/wb", {30'h0, done, wb_en}, 32'h0);
        chk("R10 reset valid", {31'h0, valid}, 32'h0);
        // ascending-after store, full ready
        run_op(mk(0, 1, 0, 1, 0, 4'd2, 16'h00F1), 32'h0000_1000, 32'h100, 100, 0);
        // ascending-before load, unaligned base, backpressure
        run_op(mk(1, 1, 0, 1, 1, 4'd3, 16'h8421), 32'h0000_2002, 32'h200, 50, 0);
        // descending-before store with PC, start pokes while busy
        run_op(mk(1, 0, 0, 1, 0, 4'd13, 16'h8003), 32'h0000_3000, 32'h0000_0800, 40, 1);
        // descending-after load with option and PC -> status restore
        run_op(mk(0, 0, 1, 0, 1, 4'd1, 16'h8010), 32'h0000_0401, 32'h300, 60, 0);
        // ascending-after store with option -> user bank
        run_op(mk(0, 1, 1, 1, 0, 4'd5, 16'h00FF), 32'h0000_5000, 32'h400, 70, 1);
        // empty mask with writeback requested
        run_op(mk(1, 1, 0, 1, 0, 4'd6, 16'h0000), 32'h0000_6000, 32'h500, 100, 1);
        // full mask descending-after load with writeback
        run_op(mk(0, 0, 0, 1, 1, 4'd7, 16'hFFFF), 32'h0000_7003, 32'h600, 70, 0);
        // descending-before wrapping below zero
        run_op(mk(1, 0, 0, 1, 0, 4'd8, 16'h0C30), 32'h0000_0008, 32'h700, 30, 1);
        summary();
    end
endmodule